// File: doc/BRIEF.md
# Dual-Queue Conversion Command Sequencer

This block walks a table of 64 conversion command words that two queues share. Queue 1 always starts at entry 0. Queue 2 starts at a begin address that is taken from `bq2_i` when its trigger is accepted. Each command word holds a pause bit and a 6-bit channel number. The sequencer reads one word at a time through a registered table port. It hands the channel to the converter and waits for the converter's acknowledge before it reads the next word. A channel value of 63 is the end-of-queue code. That word is never converted.

Queue 1 outranks queue 2. A queue 1 trigger that arrives while queue 2 runs lets queue 2 finish its current conversion and then parks it. Queue 2 picks up at its next word once queue 1 completes or pauses.

Software sees a single status word. It holds sticky completion, pause and trigger-overrun flags, two queue-state fields and the current-word pointer. The pointer obeys fixed resting rules:
- After a pause it stays on the pausing word.
- After an end-of-queue code it stays on that code word.
- After running off the table end it reads 0.
- When queue 1 is cut short at queue 2's begin address, it equals that address.

Top module: `dq_ccw_seq`

## Requirements
- R1: After reset, `status_o` is all zero and `tbl_rd_o` and `conv_req_o` are low.
- R2: A command word carries the pause bit in bit 6 and the channel in bits 5:0. A fetch raises `tbl_rd_o` for one cycle with `tbl_addr_o` equal to the pointer, and the word is taken from `tbl_data_i` in the next cycle. In the cycle after that, `conv_req_o` rises with `conv_chan_o` equal to the channel. The request stays high until `conv_done_i` is sampled high, and the next fetch follows in the next cycle.
- R3: A trigger accepted on an idle queue makes it pending on the next edge. It becomes active one edge later, and that same edge issues the first fetch: entry 0 for queue 1, or the `bq2_i` value sampled with the trigger for queue 2.
- R4: A fetched word whose channel is 63 is not converted. The queue becomes idle, its completion flag is set, and the pointer stays on that word.
- R5: After the converter acknowledges a word that has its pause bit set, the queue becomes paused and its pause flag is set. The pointer stays on that word until another queue is started. A new trigger for a paused queue resumes it at the following entry.
- R6: When entry 63 is converted without being an end-of-queue code, the queue goes on to fetch entry 0. That fetch ends the queue with the pointer at 0 and the completion flag set.
- R7: When queue 1 fetches the entry whose address equals queue 2's begin address, that word is not converted. Queue 1 completes and the pointer equals that address.
- R8: A queue 1 trigger while queue 2 is active makes queue 2 finish its current conversion and then enter the pending state. Queue 1 then runs. Queue 2 resumes at its next entry once queue 1 is idle or paused. When both queues are pending, queue 1 starts first.
- R9: A trigger for a queue that is active or pending sets that queue's overrun flag and changes nothing else.
- R10: When `clr_wr_i` is high, every flag whose `clr_mask_i` bit is 1 is cleared on the next edge. A flag that is set in the same cycle stays set.
- R11: `status_o` holds the fields below. Queue-state codes are idle 0, active 1, paused 2 and pending 3. The queue-state fields show the states one cycle after they change, while the pointer shows its new value at once.

| Bits | Field |
|---|---|
| [5:0] | Pointer |
| [7:6] | Queue 1 state |
| [9:8] | Queue 2 state |
| [10] | Queue 1 completion flag (`clr_mask_i` bit 0) |
| [11] | Queue 2 completion flag (`clr_mask_i` bit 1) |
| [12] | Queue 1 pause flag (`clr_mask_i` bit 2) |
| [13] | Queue 2 pause flag (`clr_mask_i` bit 3) |
| [14] | Queue 1 overrun flag (`clr_mask_i` bit 4) |
| [15] | Queue 2 overrun flag (`clr_mask_i` bit 5) |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig1_i | input | 1 | Queue 1 trigger pulse |
| trig2_i | input | 1 | Queue 2 trigger pulse |
| bq2_i | input | 6 | Queue 2 begin address |
| tbl_rd_o | output | 1 | Table read strobe |
| tbl_addr_o | output | 6 | Table read address |
| tbl_data_i | input | 7 | Registered table word (pause, channel) |
| conv_req_o | output | 1 | Conversion request |
| conv_chan_o | output | 6 | Channel to convert |
| conv_done_i | input | 1 | Converter acknowledge |
| clr_wr_i | input | 1 | Flag clear strobe |
| clr_mask_i | input | 6 | Write-one-to-clear flag mask |
| status_o | output | 16 | Status word view |

## Verification
The assertions check several things on every cycle:
- The fetch strobe lasts exactly one cycle, and the conversion request holds until the acknowledge.
- The end-of-queue channel never reaches the converter, and no two queues are active together.
- The pointer stays still while no queue is being started.
- The flags follow write-one-to-clear behaviour, and a set wins over a clear in the same cycle.

The resting pointer values after a pause, an end-of-queue code, a wrap and a cut at queue 2's begin address can only be shown by the bench's scenarios. The same holds for suspending and resuming queue 2 around queue 1, for overrun on a busy queue, and for the one-cycle lag of the queue-state fields.

// File: rtl/dq_pkg.sv
package dq_pkg;

    // Queue states as they appear in the status view
    typedef enum logic [1:0] {
        QS_IDLE  = 2'd0,
        QS_ACT   = 2'd1,
        QS_PAUSE = 2'd2,
        QS_PEND  = 2'd3
    } qst_e;

    // Table walker phases
    typedef enum logic [1:0] {
        EN_IDLE = 2'd0,
        EN_RD   = 2'd1,
        EN_EX   = 2'd2,
        EN_CV   = 2'd3
    } eng_e;

    // Flag positions, shared by the clear mask and the status view
    localparam int FL_CF1  = 0;
    localparam int FL_CF2  = 1;
    localparam int FL_PF1  = 2;
    localparam int FL_PF2  = 3;
    localparam int FL_TOR1 = 4;
    localparam int FL_TOR2 = 5;
    localparam int NFLAG   = 6;

endpackage

// File: rtl/dq_engine.sv
module dq_engine
    import dq_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig1_i,
    input  logic             trig2_i,
    input  logic [AW-1:0]    bq2_i,
    output logic             tbl_rd_o,
    output logic [AW-1:0]    tbl_addr_o,
    input  logic [AW:0]      tbl_data_i,
    output logic             conv_req_o,
    output logic [AW-1:0]    conv_chan_o,
    input  logic             conv_done_i,
    output logic [AW-1:0]    ptr_o,
    output qst_e             q1_o,
    output qst_e             q2_o,
    output logic [NFLAG-1:0] set_o
);

    // Last table entry; as a channel value it is the end-of-queue code
    localparam logic [AW-1:0] LAST = {AW{1'b1}};

    typedef struct packed {
        eng_e          eng;
        logic [AW-1:0] ptr;
        logic          wrap;   // pointer ran past the last entry
        qst_e          q1;
        qst_e          q2;
        logic [AW-1:0] r1;     // start / resume address per queue
        logic [AW-1:0] r2;
        logic          w1;
        logic          w2;
        logic [AW-1:0] chan;
        logic          pz;
    } st_t;

    st_t              s_q, s_d;
    logic [NFLAG-1:0] set_d;
    logic [AW-1:0]    nxt_ptr;
    logic             nxt_wrap;
    logic             q1_run;
    logic [AW-1:0]    word_ch;
    logic             word_pz;

    always_comb begin
        s_d      = s_q;
        set_d    = '0;
        nxt_ptr  = s_q.ptr + 1'b1;
        nxt_wrap = (s_q.ptr == LAST);
        q1_run   = (s_q.q1 == QS_ACT);
        word_ch  = tbl_data_i[AW-1:0];
        word_pz  = tbl_data_i[AW];

        unique case (s_q.eng)
            EN_IDLE: begin
                if (s_q.q1 == QS_PEND) begin
                    s_d.q1   = QS_ACT;
                    s_d.ptr  = s_q.r1;
                    s_d.wrap = s_q.w1;
                    s_d.eng  = EN_RD;
                end else if (s_q.q2 == QS_PEND) begin
                    s_d.q2   = QS_ACT;
                    s_d.ptr  = s_q.r2;
                    s_d.wrap = s_q.w2;
                    s_d.eng  = EN_RD;
                end
            end
            EN_RD: s_d.eng = EN_EX;
            EN_EX: begin
                if (s_q.wrap || (q1_run && s_q.ptr == bq2_i) || word_ch == LAST) begin
                    if (q1_run) begin
                        s_d.q1        = QS_IDLE;
                        set_d[FL_CF1] = 1'b1;
                    end else begin
                        s_d.q2        = QS_IDLE;
                        set_d[FL_CF2] = 1'b1;
                    end
                    s_d.eng = EN_IDLE;
                end else begin
                    s_d.chan = word_ch;
                    s_d.pz   = word_pz;
                    s_d.eng  = EN_CV;
                end
            end
            EN_CV: begin
                if (conv_done_i) begin
                    if (s_q.pz) begin
                        if (q1_run) begin
                            s_d.q1        = QS_PAUSE;
                            s_d.r1        = nxt_ptr;
                            s_d.w1        = nxt_wrap;
                            set_d[FL_PF1] = 1'b1;
                        end else begin
                            s_d.q2        = QS_PAUSE;
                            s_d.r2        = nxt_ptr;
                            s_d.w2        = nxt_wrap;
                            set_d[FL_PF2] = 1'b1;
                        end
                        s_d.eng = EN_IDLE;
                    end else if (!q1_run && s_q.q1 == QS_PEND) begin
                        s_d.q2  = QS_PEND;
                        s_d.r2  = nxt_ptr;
                        s_d.w2  = nxt_wrap;
                        s_d.eng = EN_IDLE;
                    end else begin
                        s_d.ptr  = nxt_ptr;
                        s_d.wrap = nxt_wrap;
                        s_d.eng  = EN_RD;
                    end
                end
            end
            default: ;
        endcase

        if (trig1_i) begin
            if (s_q.q1 == QS_ACT || s_q.q1 == QS_PEND) begin
                set_d[FL_TOR1] = 1'b1;
            end else begin
                s_d.q1 = QS_PEND;
                if (s_q.q1 == QS_IDLE) begin
                    s_d.r1 = '0;
                    s_d.w1 = 1'b0;
                end
            end
        end
        if (trig2_i) begin
            if (s_q.q2 == QS_ACT || s_q.q2 == QS_PEND) begin
                set_d[FL_TOR2] = 1'b1;
            end else begin
                s_d.q2 = QS_PEND;
                if (s_q.q2 == QS_IDLE) begin
                    s_d.r2 = bq2_i;
                    s_d.w2 = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tbl_rd_o    = (s_q.eng == EN_RD);
    assign tbl_addr_o  = s_q.ptr;
    assign conv_req_o  = (s_q.eng == EN_CV);
    assign conv_chan_o = s_q.chan;
    assign ptr_o       = s_q.ptr;
    assign q1_o        = s_q.q1;
    assign q2_o        = s_q.q2;
    assign set_o       = set_d;

    a_r2_fetch_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_rd_o |=> (!tbl_rd_o && !conv_req_o));

    a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req_o && !conv_done_i) |=> conv_req_o);

    a_r4_no_eoq_convert: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req_o |-> (conv_chan_o != LAST));

    a_r8_single_active: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_q.q1 == QS_ACT && s_q.q2 == QS_ACT));

    a_r5_ptr_rests: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.eng == EN_IDLE && s_q.q1 != QS_PEND && s_q.q2 != QS_PEND) |=> $stable(ptr_o));

endmodule

// File: rtl/dq_flags.sv
module dq_flags
    import dq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set_i,
    input  logic             clr_wr_i,
    input  logic [NFLAG-1:0] clr_mask_i,
    output logic [NFLAG-1:0] flg_o
);

    logic [NFLAG-1:0] flg_q, flg_d;

    always_comb begin
        flg_d = flg_q;
        for (int k = 0; k < NFLAG; k++) begin
            if (set_i[k])                         flg_d[k] = 1'b1;
            else if (clr_wr_i && clr_mask_i[k])   flg_d[k] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    assign flg_o = flg_q;

    for (genvar k = 0; k < NFLAG; k++) begin : g_chk
        a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[k] |=> flg_o[k]);
        a_r10_w1c: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_wr_i && clr_mask_i[k] && !set_i[k]) |=> !flg_o[k]);
        a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_i[k] && !(clr_wr_i && clr_mask_i[k])) |=> $stable(flg_o[k]));
    end

endmodule

// File: rtl/dq_stview.sv
module dq_stview
    import dq_pkg::*;
#(
    parameter int AW = 6,
    localparam int SW = AW + 4 + NFLAG
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    ptr_i,
    input  qst_e             q1_i,
    input  qst_e             q2_i,
    input  logic [NFLAG-1:0] flg_i,
    output logic [SW-1:0]    status_o
);

    typedef struct packed {
        qst_e q2;
        qst_e q1;
    } qv_t;

    qv_t qv_q, qv_d;

    always_comb begin
        qv_d.q1 = q1_i;
        qv_d.q2 = q2_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) qv_q <= '0;
        else        qv_q <= qv_d;
    end

    assign status_o = {flg_i, qv_q, ptr_i};

endmodule

// File: rtl/dq_ccw_seq.sv
module dq_ccw_seq
    import dq_pkg::*;
#(
    parameter int AW = 6,
    localparam int SW = AW + 4 + NFLAG
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig1_i,
    input  logic             trig2_i,
    input  logic [AW-1:0]    bq2_i,
    output logic             tbl_rd_o,
    output logic [AW-1:0]    tbl_addr_o,
    input  logic [AW:0]      tbl_data_i,
    output logic             conv_req_o,
    output logic [AW-1:0]    conv_chan_o,
    input  logic             conv_done_i,
    input  logic             clr_wr_i,
    input  logic [NFLAG-1:0] clr_mask_i,
    output logic [SW-1:0]    status_o
);

    logic [AW-1:0]    ptr_s;
    qst_e             q1_s, q2_s;
    logic [NFLAG-1:0] set_s, flg_s;

    dq_engine #(.AW(AW)) u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig1_i     (trig1_i),
        .trig2_i     (trig2_i),
        .bq2_i       (bq2_i),
        .tbl_rd_o    (tbl_rd_o),
        .tbl_addr_o  (tbl_addr_o),
        .tbl_data_i  (tbl_data_i),
        .conv_req_o  (conv_req_o),
        .conv_chan_o (conv_chan_o),
        .conv_done_i (conv_done_i),
        .ptr_o       (ptr_s),
        .q1_o        (q1_s),
        .q2_o        (q2_s),
        .set_o       (set_s)
    );

    dq_flags u_flg (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (set_s),
        .clr_wr_i   (clr_wr_i),
        .clr_mask_i (clr_mask_i),
        .flg_o      (flg_s)
    );

    dq_stview #(.AW(AW)) u_view (
        .clk      (clk),
        .rst_n    (rst_n),
        .ptr_i    (ptr_s),
        .q1_i     (q1_s),
        .q2_i     (q2_s),
        .flg_i    (flg_s),
        .status_o (status_o)
    );

endmodule

// File: tb/sim_dq_ccw_seq.sv
module sim_dq_ccw_seq;

    localparam int CLK_P = 10;
    localparam int WDOG  = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig1 = 1'b0, trig2 = 1'b0;
    logic [5:0]  bq2 = 6'd40;
    logic        tbl_rd;
    logic [5:0]  tbl_addr;
    logic [6:0]  rdata = '0;
    logic        conv_req;
    logic [5:0]  conv_chan;
    logic        done = 1'b0;
    logic        clr_wr = 1'b0;
    logic [5:0]  clr_mask = '0;
    logic [15:0] status;

    logic [6:0]  tbl [64];

    int n_chk = 0, n_bad = 0, cyc = 0, cv_cnt = 0;
    bit saw_cf1 = 0;

    // reference model state
    int m_eng, m_ptr, m_wrap, m_chan, m_pz;
    int m_q [2];
    int m_r [2];
    int m_rw [2];
    int m_qv [2];
    int m_fl [6];

    dq_ccw_seq u0 (
        .clk(clk), .rst_n(rst_n), .trig1_i(trig1), .trig2_i(trig2), .bq2_i(bq2),
        .tbl_rd_o(tbl_rd), .tbl_addr_o(tbl_addr), .tbl_data_i(rdata),
        .conv_req_o(conv_req), .conv_chan_o(conv_chan), .conv_done_i(done),
        .clr_wr_i(clr_wr), .clr_mask_i(clr_mask), .status_o(status)
    );

    always #(CLK_P/2) clk = ~clk;

    always @(posedge clk) if (tbl_rd) rdata <= tbl[tbl_addr];

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic model_reset();
        m_eng = 0; m_ptr = 0; m_wrap = 0; m_chan = 0; m_pz = 0;
        for (int i = 0; i < 2; i++) begin
            m_q[i] = 0; m_r[i] = 0; m_rw[i] = 0; m_qv[i] = 0;
        end
        for (int k = 0; k < 6; k++) m_fl[k] = 0;
    endtask

    // one clock of the behavioural queue model (0 idle,1 active,2 paused,3 pending)
    task automatic model_step();
        int oq [2];
        int st [6];
        int oe, op, a, nx, nw, ch;
        bit tg;
        oq[0] = m_q[0]; oq[1] = m_q[1];
        oe = m_eng; op = m_ptr;
        for (int k = 0; k < 6; k++) st[k] = 0;
        a  = (oq[0] == 1) ? 0 : 1;
        nx = (op + 1) % 64;
        nw = (op == 63) ? 1 : 0;
        if (oe == 0) begin
            for (int i = 0; i < 2; i++) begin
                if (m_eng == 0 && oq[i] == 3) begin
                    m_q[i] = 1; m_ptr = m_r[i]; m_wrap = m_rw[i]; m_eng = 1;
                end
            end
        end else if (oe == 1) begin
            m_eng = 2;
        end else if (oe == 2) begin
            ch = int'(tbl[op][5:0]);
            if (m_wrap == 1 || (a == 0 && op == int'(bq2)) || ch == 63) begin
                m_q[a] = 0; st[a] = 1; m_eng = 0;
            end else begin
                m_chan = ch; m_pz = int'(tbl[op][6]); m_eng = 3;
            end
        end else if (done) begin
            if (m_pz == 1) begin
                m_q[a] = 2; st[2 + a] = 1; m_r[a] = nx; m_rw[a] = nw; m_eng = 0;
            end else if (a == 1 && oq[0] == 3) begin
                m_q[1] = 3; m_r[1] = nx; m_rw[1] = nw; m_eng = 0;
            end else begin
                m_ptr = nx; m_wrap = nw; m_eng = 1;
            end
        end
        for (int i = 0; i < 2; i++) begin
            tg = (i == 0) ? trig1 : trig2;
            if (tg) begin
                if (oq[i] == 1 || oq[i] == 3) st[4 + i] = 1;
                else begin
                    m_q[i] = 3;
                    if (oq[i] == 0) begin
                        m_r[i] = (i == 0) ? 0 : int'(bq2);
                        m_rw[i] = 0;
                    end
                end
            end
        end
        for (int k = 0; k < 6; k++) begin
            if (st[k] == 1) m_fl[k] = 1;
            else if (clr_wr && clr_mask[k]) m_fl[k] = 0;
        end
        m_qv[0] = oq[0]; m_qv[1] = oq[1];
    endtask

    function automatic int exp_status();
        int v;
        v = m_ptr + (m_qv[0] << 6) + (m_qv[1] << 8);
        for (int k = 0; k < 6; k++) v += m_fl[k] << (10 + k);
        return v;
    endfunction

    // model step, per-cycle compare, converter responder, watchdog
    always @(negedge clk) begin
        cyc++;
        if (!rst_n) model_reset();
        else        model_step();
        chk("R2", "tbl_rd_o", int'(tbl_rd), (m_eng == 1) ? 1 : 0);
        if (m_eng == 1) chk("R2", "tbl_addr_o", int'(tbl_addr), m_ptr);
        chk("R2", "conv_req_o", int'(conv_req), (m_eng == 3) ? 1 : 0);
        if (m_eng == 3) chk("R2", "conv_chan_o", int'(conv_chan), m_chan);
        chk("R11", "status_o", int'(status), exp_status());
        if (status[10]) saw_cf1 = 1;
        if (conv_req && !done) begin
            cv_cnt++;
            if (cv_cnt >= 2) begin done = 1'b1; cv_cnt = 0; end
        end else begin
            done = 1'b0;
        end
        if (cyc > WDOG) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc, WDOG);
            summary();
            $finish;
        end
    end

    task automatic wait_cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    task automatic pulse(bit q1, bit q2);
        @(negedge clk); #1;
        trig1 = q1; trig2 = q2;
        @(negedge clk); #1;
        trig1 = 1'b0; trig2 = 1'b0;
    endtask

    task automatic clear(logic [5:0] m);
        @(negedge clk); #1;
        clr_wr = 1'b1; clr_mask = m;
        @(negedge clk); #1;
        clr_wr = 1'b0; clr_mask = '0;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) tbl[i] = 7'd63;
        tbl[0] = 7'd5;
        tbl[1] = 7'h40 | 7'd7;
        tbl[2] = 7'd3;
        tbl[3] = 7'd63;
        for (int i = 60; i < 64; i++) tbl[i] = 7'(i - 49);

        wait_cyc(3);
        chk("R1", "status after reset", int'(status), 0);
        chk("R1", "tbl_rd_o after reset", int'(tbl_rd), 0);
        chk("R1", "conv_req_o after reset", int'(conv_req), 0);
        rst_n = 1'b1;
        wait_cyc(2);

        // queue 1 start, pause, overrun, resume to end-of-queue
        pulse(1, 0);
        wait_cyc(1);
        chk("R3", "q1 first fetch strobe", int'(tbl_rd), 1);
        chk("R3", "q1 first fetch addr", int'(tbl_addr), 0);
        chk("R11", "q1 state lags pointer", int'(status[7:6]), 3);
        wait_cyc(2);
        pulse(1, 0);
        wait_cyc(40);
        chk("R5", "pointer at pause word", int'(status[5:0]), 1);
        chk("R5", "q1 paused", int'(status[7:6]), 2);
        chk("R5", "PF1", int'(status[12]), 1);
        chk("R9", "TOR1 on busy trigger", int'(status[14]), 1);
        chk("R9", "no CF1 from busy trigger", int'(status[10]), 0);
        pulse(1, 0);
        wait_cyc(40);
        chk("R4", "pointer at end code", int'(status[5:0]), 3);
        chk("R4", "CF1", int'(status[10]), 1);
        chk("R4", "q1 idle", int'(status[7:6]), 0);
        clear(6'h3F);
        chk("R10", "flags cleared", int'(status[15:10]), 0);

        // queue 2 wrap with queue 1 preemption
        tbl[0] = 7'd9;
        tbl[1] = 7'd63;
        bq2 = 6'd60;
        pulse(0, 1);
        wait_cyc(1);
        chk("R3", "q2 first fetch addr", int'(tbl_addr), 60);
        chk("R11", "q2 state lags pointer", int'(status[9:8]), 3);
        wait_cyc(4);
        pulse(1, 0);
        wait_cyc(6);
        chk("R8", "q2 suspended", int'(status[9:8]), 3);
        wait_cyc(80);
        chk("R6", "pointer wrapped to 0", int'(status[5:0]), 0);
        chk("R6", "CF2", int'(status[11]), 1);
        chk("R8", "q1 completed during q2", int'(status[10]), 1);
        chk("R8", "q2 idle", int'(status[9:8]), 0);
        clear(6'h3F);

        // queue 1 cut short at queue 2 begin address
        tbl[0] = 7'd1; tbl[1] = 7'd2; tbl[2] = 7'd3; tbl[3] = 7'd4;
        bq2 = 6'd3;
        pulse(1, 0);
        wait_cyc(60);
        chk("R7", "pointer equals begin address", int'(status[5:0]), 3);
        chk("R7", "CF1 at boundary", int'(status[10]), 1);
        clear(6'h3F);

        // set beats clear in the same cycle
        saw_cf1 = 0;
        @(negedge clk); #1;
        clr_wr = 1'b1; clr_mask = 6'h01;
        pulse(1, 0);
        wait_cyc(60);
        chk("R10", "CF1 seen despite clear", int'(saw_cf1), 1);
        chk("R10", "CF1 cleared afterwards", int'(status[10]), 0);
        clr_wr = 1'b0; clr_mask = '0;

        // both queues triggered together
        tbl[0] = 7'd9; tbl[1] = 7'd63; tbl[2] = 7'd63; tbl[3] = 7'd63;
        bq2 = 6'd60;
        pulse(1, 1);
        wait_cyc(1);
        chk("R8", "queue 1 first when both pending", int'(tbl_addr), 0);
        wait_cyc(80);
        chk("R8", "both complete", int'(status[11:10]), 3);
        chk("R6", "final pointer 0", int'(status[5:0]), 0);

        summary();
        $finish;
    end

endmodule